// File: doc/BRIEF.md
# Byte-wide nonvolatile memory programming controller

This block sits on an 8-bit register bus and fronts a small on-chip array of nonvolatile bytes. Software loads a 9-bit byte address (low byte and high bit written separately) and a data byte. It then issues commands through a control register. A read strobe fetches the addressed byte into the data register in a single cycle. A program command runs one of three timed actions on the addressed byte. The combined action erases the byte and then writes it. The split actions erase only or write only. Each action keeps the block busy for a number of clock cycles derived from a cycles-per-millisecond parameter.

A program command is accepted only shortly after an arming bit has been set, which guards against stray writes. The mode bits cannot change while a program action runs. A reset that lands during programming leaves the running action and its mode in place. A ready interrupt is asserted whenever it is enabled and nothing is programming. The storage is a behavioural byte array. Erase sets a byte to all ones, and write-only clears bits, so the stored value becomes old AND new.

Top module: `nvbyte_ctrl`

## Requirements
- R1: After reset with no program action running, the control readback is 0x00, the data register is 0x00 and `irq_ready` is low.
- R2: Control bits 5:4 select the action. 00 stores the data byte, 01 sets the byte to 0xFF, 10 stores old AND data, and 11 starts nothing and leaves the busy bit (control bit 1) low.
- R3: The busy bit stays high for ceil(34*CYC_PER_MS/10) cycles in mode 00 and for ceil(18*CYC_PER_MS/10) cycles in modes 01 and 10, then clears by itself.
- R4: While the busy bit is high, control writes leave the mode bits unchanged.
- R5: A reset during a program action keeps the busy bit and the mode bits, and the action still completes. A reset while idle clears the mode bits to 00.
- R6: A control write with bit 1 set starts an action only if the arming bit (control bit 2) was written to 1 within the previous 4 cycles, that is, at most 4 clock edges earlier.
- R7: The arming bit clears by itself 4 clock edges after it was written.
- R8: A control write with bit 0 set, while idle, loads the byte at the current address into the data register at that clock edge. While busy, this write leaves the data register unchanged.
- R9: `irq_ready` is high exactly when control bit 3 is set and the busy bit is low.
- R10: Addresses 0 through 511 each select their own byte. The high address bit is bus bit 0 of a write with `bus_sel`=1, and the low eight bits come from a write with `bus_sel`=0.
- R11: Control bits 7:6 and bit 0 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select: 0 address low, 1 address high, 2 data, 3 control |
| bus_wdata | input | 8 | Write data |
| reg_addr | output | ADDR_W | Address register readback |
| reg_data | output | 8 | Data register readback |
| reg_ctrl | output | 8 | Control register readback |
| irq_ready | output | 1 | Ready interrupt |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a read strobe and a running program action. The bench fires read commands and data writes while the busy bit is high, and it expects the data register to hold the last bus-written value. The second pair is a reset and a running action. The bench drops reset partway through an erase, checks that the mode and busy bits survived, and then reads the byte back as 0xFF once the action ends. The bench also places program commands at the fourth and fifth edge after arming to judge the edge of the arming window.

// File: rtl/nvbyte_pkg.sv
package nvbyte_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      MODE_ERASE_WRITE = 2'b00,
      MODE_ERASE       = 2'b01,
      MODE_WRITE       = 2'b10,
      MODE_RSVD        = 2'b11
   } nv_mode_e;

   typedef enum logic [1:0] {
      SEL_ADDR_LO = 2'd0,
      SEL_ADDR_HI = 2'd1,
      SEL_DATA    = 2'd2,
      SEL_CTRL    = 2'd3
   } reg_sel_e;

   localparam int CB_RD   = 0;
   localparam int CB_PGM  = 1;
   localparam int CB_ARM  = 2;
   localparam int CB_IRQE = 3;
   localparam int CB_MODE = 4;
endpackage

// File: rtl/nvbyte_timer.sv
module nvbyte_timer #(
   parameter int CYC_PER_MS     = 16000,
   parameter int LONG_TENTHS_MS = 34,
   parameter int SHORT_TENTHS_MS = 18
) (
   input  logic clk,
   input  logic start,
   input  logic long_op,
   output logic busy,
   output logic done
);
   localparam int LONG_CYC  = (LONG_TENTHS_MS * CYC_PER_MS + 9) / 10;
   localparam int SHORT_CYC = (SHORT_TENTHS_MS * CYC_PER_MS + 9) / 10;
   localparam int CNT_W     = $clog2(LONG_CYC + 1);

   generate
      if (CYC_PER_MS < 1) begin : g_bad_rate
         $error("CYC_PER_MS must be at least 1");
      end
      if (SHORT_CYC > LONG_CYC) begin : g_bad_order
         $error("short action must not outlast the long one");
      end
   endgenerate

   // power-up value: the countdown is not touched by rst_n
   logic [CNT_W-1:0] cnt_q = '0;

   always_ff @(posedge clk) begin
      if (start)
         cnt_q <= long_op ? CNT_W'(LONG_CYC) : CNT_W'(SHORT_CYC);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
   assign done = (cnt_q == CNT_W'(1));

   p_no_restart_r3: assert property (@(posedge clk) start |-> !busy);
endmodule

// File: rtl/nvbyte_array.sv
module nvbyte_array
   import nvbyte_pkg::*;
#(
   parameter int ADDR_W = 9
) (
   input  logic              clk,
   input  logic              commit,
   input  nv_mode_e          op_mode,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [BYTE_W-1:0] op_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [BYTE_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [BYTE_W-1:0] mem [DEPTH];
   logic [BYTE_W-1:0] old_byte;
   logic [BYTE_W-1:0] new_byte;

   assign old_byte = mem[op_addr];
   assign rd_data  = mem[rd_addr];

   for (genvar b = 0; b < BYTE_W; b++) begin : g_cell
      always_comb begin
         unique case (op_mode)
            MODE_ERASE: new_byte[b] = 1'b1;
            MODE_WRITE: new_byte[b] = old_byte[b] & op_data[b];
            default:    new_byte[b] = op_data[b];
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (commit) mem[op_addr] <= new_byte;
   end
endmodule

// File: rtl/nvbyte_ctrl.sv
module nvbyte_ctrl
   import nvbyte_pkg::*;
#(
   parameter int ADDR_W          = 9,
   parameter int CYC_PER_MS      = 16000,
   parameter int ARM_WINDOW      = 4,
   parameter int LONG_TENTHS_MS  = 34,
   parameter int SHORT_TENTHS_MS = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [1:0]        bus_sel,
   input  logic [7:0]        bus_wdata,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [7:0]        reg_data,
   output logic [7:0]        reg_ctrl,
   output logic              irq_ready
);
   localparam int WIN_W = $clog2(ARM_WINDOW + 1);

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
         $error("ADDR_W must lie in 9..16");
      end
      if (ARM_WINDOW < 1) begin : g_bad_win
         $error("ARM_WINDOW must be at least 1");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_q;
   logic [BYTE_W-1:0] data_q;
   nv_mode_e          mode_q;
   logic              irqe_q;
   logic              arm_q;
   logic [WIN_W-1:0]  arm_cnt_q;
   logic [ADDR_W-1:0] op_addr_q;
   logic [BYTE_W-1:0] op_data_q;
   nv_mode_e          op_mode_q;

   logic     busy, done;
   logic     ctrl_wr, start, rd_go;
   nv_mode_e wr_mode;
   logic [BYTE_W-1:0] rd_byte;
   logic     unused_bits;

   assign unused_bits = ^bus_wdata;

   assign ctrl_wr = rst_n && bus_we && (reg_sel_e'(bus_sel) == SEL_CTRL);
   assign wr_mode = busy ? mode_q : nv_mode_e'(bus_wdata[CB_MODE+1:CB_MODE]);
   assign start   = ctrl_wr && bus_wdata[CB_PGM] && arm_q && !busy
                    && (wr_mode != MODE_RSVD);
   assign rd_go   = ctrl_wr && bus_wdata[CB_RD] && !busy && !start;

   // address: not reset, software loads it before use
   always_ff @(posedge clk) begin
      if (rst_n && bus_we) begin
         if (reg_sel_e'(bus_sel) == SEL_ADDR_LO)
            addr_q[7:0] <= bus_wdata;
         else if (reg_sel_e'(bus_sel) == SEL_ADDR_HI)
            addr_q[ADDR_W-1:8] <= bus_wdata[ADDR_W-9:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q    <= '0;
         irqe_q    <= 1'b0;
         arm_q     <= 1'b0;
         arm_cnt_q <= '0;
         if (!busy) mode_q <= MODE_ERASE_WRITE;
      end else begin
         if (rd_go)
            data_q <= rd_byte;
         else if (!busy && bus_we && reg_sel_e'(bus_sel) == SEL_DATA)
            data_q <= bus_wdata;
         else if (busy && bus_we && reg_sel_e'(bus_sel) == SEL_DATA)
            data_q <= bus_wdata;

         if (ctrl_wr) begin
            mode_q <= wr_mode;
            irqe_q <= bus_wdata[CB_IRQE];
            if (!start && bus_wdata[CB_ARM]) begin
               arm_q     <= 1'b1;
               arm_cnt_q <= WIN_W'(ARM_WINDOW);
            end else begin
               arm_q     <= 1'b0;
               arm_cnt_q <= '0;
            end
         end else if (arm_q) begin
            if (arm_cnt_q == WIN_W'(1)) begin
               arm_q     <= 1'b0;
               arm_cnt_q <= '0;
            end else begin
               arm_cnt_q <= arm_cnt_q - 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (start) begin
         op_addr_q <= addr_q;
         op_data_q <= data_q;
         op_mode_q <= wr_mode;
      end
   end

   nvbyte_timer #(
      .CYC_PER_MS     (CYC_PER_MS),
      .LONG_TENTHS_MS (LONG_TENTHS_MS),
      .SHORT_TENTHS_MS(SHORT_TENTHS_MS)
   ) u_timer (
      .clk    (clk),
      .start  (start),
      .long_op(wr_mode == MODE_ERASE_WRITE),
      .busy   (busy),
      .done   (done)
   );

   nvbyte_array #(.ADDR_W(ADDR_W)) u_array (
      .clk    (clk),
      .commit (done),
      .op_mode(op_mode_q),
      .op_addr(op_addr_q),
      .op_data(op_data_q),
      .rd_addr(addr_q),
      .rd_data(rd_byte)
   );

   assign reg_addr  = addr_q;
   assign reg_data  = data_q;
   assign reg_ctrl  = {2'b00, mode_q, irqe_q, arm_q, busy, 1'b0};
   assign irq_ready = irqe_q && !busy;

   p_mode_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(mode_q));

   p_start_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(arm_q));

   p_arm_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
      arm_q |-> (arm_cnt_q != '0 && arm_cnt_q <= WIN_W'(ARM_WINDOW)));

   p_read_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(bus_we && reg_sel_e'(bus_sel) == SEL_DATA)) |=> $stable(data_q));

   p_irq_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && irqe_q && !ctrl_wr) |=> irq_ready);
endmodule

// File: tb/nvbyte_ctrl_test.sv
`timescale 1ns/1ps
module nvbyte_ctrl_test;
   localparam int CPM      = 10;
   localparam int LONG_N   = (34 * CPM + 9) / 10;
   localparam int SHORT_N  = (18 * CPM + 9) / 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       bus_we;
   logic [1:0] bus_sel;
   logic [7:0] bus_wdata;
   logic [8:0] reg_addr;
   logic [7:0] reg_data;
   logic [7:0] reg_ctrl;
   logic       irq_ready;

   always #2 clk = ~clk;

   nvbyte_ctrl #(.ADDR_W(9), .CYC_PER_MS(CPM)) uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
      .bus_wdata(bus_wdata), .reg_addr(reg_addr), .reg_data(reg_data),
      .reg_ctrl(reg_ctrl), .irq_ready(irq_ready));

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   logic [7:0] model [512];
   bit         known [512];

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog act=%0d exp<150000", cyc);
         finish_run();
      end
   end

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
      end
   endtask

   function automatic int busy_len(int m);
      return (m == 0) ? LONG_N : SHORT_N;
   endfunction

   function automatic logic [7:0] apply(logic [7:0] old, logic [7:0] d, int m);
      case (m)
         0: return d;
         1: return 8'hFF;
         default: return old & d;
      endcase
   endfunction

   function automatic logic [7:0] cw(int m, bit ie, bit arm, bit pgm, bit rd);
      return {2'b00, 2'(m), ie, arm, pgm, rd};
   endfunction

   task automatic bw(int sel, logic [7:0] d);
      bus_we = 1'b1; bus_sel = 2'(sel); bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic set_addr(int a);
      bw(0, 8'(a));
      bw(1, {7'b0, 1'(a >> 8)});
   endtask

   task automatic start_op(int a, logic [7:0] d, int m, bit ie);
      set_addr(a);
      bw(2, d);
      bw(3, cw(m, ie, 1, 0, 0));
      bw(3, cw(m, ie, 0, 1, 0));
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (reg_ctrl[1] && n < 2000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic do_prog(int a, logic [7:0] d, int m);
      int n;
      start_op(a, d, m, 0);
      check("R3 busy set after start", int'(reg_ctrl[1]), 1);
      wait_idle(n);
      check("R3 busy length", n, busy_len(m));
      model[a] = apply(model[a], d, m);
      known[a] = 1'b1;
   endtask

   task automatic do_read(int a, string req);
      set_addr(a);
      bw(3, cw(0, 0, 0, 0, 1));
      check(req, int'(reg_data), int'(model[a]));
   endtask

   initial begin
      int n;
      void'($urandom(32'd4242));
      rst_n = 1'b0; bus_we = 1'b0; bus_sel = 2'd0; bus_wdata = 8'h00;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      check("R1 ctrl after reset", int'(reg_ctrl), 8'h00);
      check("R1 data after reset", int'(reg_data), 8'h00);
      check("R1 irq after reset", int'(irq_ready), 0);

      // R10 both ends of the address range
      do_prog(0, 8'h5A, 0);
      do_prog(511, 8'hC3, 0);
      check("R10 address readback", int'(reg_addr), 511);
      do_read(0, "R10 byte 0");
      do_read(511, "R10 byte 511");

      // R2 split modes
      do_prog(0, 8'h00, 1);
      do_read(0, "R2 erase gives FF");
      do_prog(0, 8'h96, 2);
      do_read(0, "R2 write-only AND 96");
      do_prog(0, 8'h0F, 2);
      do_read(0, "R2 write-only AND 0F");

      // R2 reserved mode starts nothing
      set_addr(0);
      bw(3, cw(3, 0, 1, 0, 0));
      bw(3, cw(3, 0, 0, 1, 0));
      check("R2 mode 11 no busy", int'(reg_ctrl[1]), 0);
      do_read(0, "R2 mode 11 byte kept");

      // R6 arming window
      bw(3, cw(0, 0, 0, 1, 0));
      check("R6 no start unarmed", int'(reg_ctrl[1]), 0);
      set_addr(5); bw(2, 8'h11);
      bw(3, cw(0, 0, 1, 0, 0));
      repeat (4) @(negedge clk);
      bw(3, cw(0, 0, 0, 1, 0));
      check("R6 no start at edge 5", int'(reg_ctrl[1]), 0);
      bw(3, cw(0, 0, 1, 0, 0));
      repeat (3) @(negedge clk);
      bw(3, cw(0, 0, 0, 1, 0));
      check("R6 start at edge 4", int'(reg_ctrl[1]), 1);
      wait_idle(n);
      model[5] = 8'h11; known[5] = 1'b1;
      do_read(5, "R6 byte written");

      // R7 arming bit self-clear
      bw(3, cw(0, 0, 1, 0, 0));
      check("R7 arm set", int'(reg_ctrl[2]), 1);
      repeat (3) @(negedge clk);
      check("R7 arm after 3 edges", int'(reg_ctrl[2]), 1);
      @(negedge clk);
      check("R7 arm after 4 edges", int'(reg_ctrl[2]), 0);

      // R4, R8, R9 during a running erase
      start_op(7, 8'h00, 1, 1);
      check("R9 irq low while busy", int'(irq_ready), 0);
      bw(3, cw(2, 1, 0, 0, 0));
      check("R4 mode locked", int'(reg_ctrl[5:4]), 1);
      bw(2, 8'h77);
      bw(3, cw(2, 1, 0, 0, 1));
      check("R8 read ignored while busy", int'(reg_data), 8'h77);
      wait_idle(n);
      check("R9 irq high when idle", int'(irq_ready), 1);
      check("R4 mode after action", int'(reg_ctrl[5:4]), 1);
      model[7] = 8'hFF; known[7] = 1'b1;
      do_read(7, "R8 read after idle");
      check("R9 irq low when disabled", int'(irq_ready), 0);

      // R5 reset during a running erase
      do_prog(9, 8'h33, 0);
      start_op(9, 8'h00, 1, 1);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      check("R5 busy kept over reset", int'(reg_ctrl[1]), 1);
      check("R5 mode kept over reset", int'(reg_ctrl[5:4]), 1);
      check("R5 irq enable cleared", int'(reg_ctrl[3]), 0);
      wait_idle(n);
      model[9] = 8'hFF;
      do_read(9, "R5 action completed");
      bw(3, cw(2, 0, 0, 0, 0));
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check("R5 idle reset clears mode", int'(reg_ctrl[5:4]), 0);

      // random mix
      for (int i = 0; i < 25; i++) begin
         int a = int'($urandom % 512);
         logic [7:0] d = 8'($urandom);
         int m = int'($urandom % 3);
         if (!known[a] && m == 2) m = 0;
         do_prog(a, d, m);
         do_read(a, "R2 random readback");
      end

      // R11 reserved and strobe bits read zero
      bw(3, 8'hFF);
      check("R11 ctrl readback", int'(reg_ctrl), 8'h3C);

      finish_run();
   end
endmodule